// File: doc/BRIEF.md
# Epoch Termination and Lazy Commit Controller

This per-processor controller decides when the running speculative epoch ends and when older uncommitted epochs must commit. It counts the cache lines that the running epoch touches for the first time and the instructions that epoch retires. It ends the epoch when either count reaches its limit, when a synchronization operation is performed, or when a cache conflict names the running epoch. A single-cycle end pulse is produced, which the core treats like an epoch-creation instruction, and the next epoch starts at once with a fresh local ID.

Commit is lazy. Uncommitted local epochs form an ordered list, from the oldest to the running one. Epochs leave the list only under pressure. One pressure is the cap on list length, which can be set to 2, 4 or 8. The other is a conflict in a cache set whose lines are all uncommitted; that conflict forces the owner of the victim line and every older local epoch to commit. Commits leave one per cycle, in ID order, always taken from the head of the list. The end and commit outputs are combinational from the event inputs and the list state, so a commit forced by the cap appears in the same cycle as the end pulse that caused it.

Top module: `epoch_ctrl`

## Requirements
- R1: After reset the running epoch ID is 0, the list holds one epoch, and neither end_epoch_o nor commit_o is asserted.
- R2: When line_new_i brings the running epoch's first-touch line count to max_size_i or above, end_epoch_o is high in that same cycle. A max_size_i of 0 ends the epoch on any new line.
- R3: When inst_ret_i brings the running epoch's retired-instruction count to the MAX_INST parameter (default 65,536), end_epoch_o is high in that same cycle.
- R4: sync_i raises end_epoch_o in the same cycle. On the next cycle cur_epoch_o is the previous ID plus one, modulo 2^ID_W.
- R5: Both counters clear at every epoch end, whatever caused it. The line and instruction that arrive in the ending cycle are counted toward the ending epoch.
- R6: Any combination of end causes in one cycle gives a single end pulse, and the ID advances by exactly one. Without an end, the ID holds.
- R7: cap_sel_i selects the cap: 0 selects 2, 1 selects 4, and 2 or 3 select 8. When the list holds as many epochs as the cap and an end occurs, the oldest epoch commits in that same cycle and the list length is unchanged. Below the cap, ends cause no commit.
- R8: A conflict naming an uncommitted epoch at position k (0 = oldest) commits the k+1 oldest epochs. They commit one per cycle in consecutive cycles, and the first commit occurs in the conflict's own cycle.
- R9: A conflict naming an ID that is not in the list has no effect: no commit, and the list length is unchanged.
- R10: A conflict naming the running epoch also ends that epoch in the same cycle. The ended epoch is committed after all of its predecessors.
- R11: At most one commit occurs per cycle, and the list length stays between 1 and 8. A cap commit that coincides with a conflict drain is served by the same single commit. After the cap is lowered, the list shrinks by one per cycle until it fits.
- R12: commit_id_o is always the oldest uncommitted ID, and successive commits carry consecutive IDs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| max_size_i | input | SIZE_W | Threshold on the number of first-touch lines per epoch |
| cap_sel_i | input | 2 | Cap select on uncommitted epochs (0: 2, 1: 4, 2/3: 8) |
| line_new_i | input | 1 | Running epoch touched a line for the first time |
| inst_ret_i | input | 1 | Running epoch retired one instruction |
| sync_i | input | 1 | Synchronization operation performed |
| conflict_i | input | 1 | Set conflict with all lines uncommitted |
| conflict_id_i | input | ID_W | Local epoch ID owning the victim line |
| end_epoch_o | output | 1 | Running epoch ends this cycle |
| cur_epoch_o | output | ID_W | ID of the running epoch |
| commit_o | output | 1 | One epoch commits this cycle |
| commit_id_o | output | ID_W | ID of the committing epoch |
| live_cnt_o | output | 4 | Number of uncommitted epochs, including the running one |

## Verification
The interesting overlap is an end pulse landing in the same cycle as a forced commit. A cap-induced commit can coincide with an end, and a conflict drain still in progress can coincide with a new end that would exceed the cap. The bench provokes both cases. It fills the list to its cap with synchronization events, sends a conflict followed by synchronization events while the drain proceeds, and lowers the cap while epochs keep ending. A queue-based reference model predicts, for every cycle, the end pulse, whether a commit occurs and its ID, the running ID and the list length. A mismatch is judged by requiring a single commit per cycle, drawn from the list head, with the list length moving by exactly the end minus the commit.

// File: rtl/epoch_pkg.sv
`timescale 1ns/1ps
package epoch_pkg;
  localparam int unsigned CNT_W = 4;

  typedef enum logic [1:0] {
    CAP_2  = 2'd0,
    CAP_4  = 2'd1,
    CAP_8  = 2'd2,
    CAP_8X = 2'd3
  } cap_sel_e;

  function automatic logic [CNT_W-1:0] cap_decode(input logic [1:0] sel);
    case (cap_sel_e'(sel))
      CAP_2:   return CNT_W'(2);
      CAP_4:   return CNT_W'(4);
      default: return CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/epoch_thr_cnt.sv
`timescale 1ns/1ps
module epoch_thr_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   nxt;

  assign nxt   = {1'b0, cnt_q} + (W+1)'(1);
  assign hit_o = inc_i && (nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= nxt[W-1:0];
  end
endmodule

// File: rtl/epoch_list.sv
`timescale 1ns/1ps
module epoch_list
  import epoch_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             end_i,
  input  logic             conflict_i,
  input  logic [ID_W-1:0]  conflict_id_i,
  input  logic [CNT_W-1:0] cap_i,
  output logic             on_run_o,
  output logic             commit_o,
  output logic [ID_W-1:0]  commit_id_o,
  output logic [ID_W-1:0]  cur_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [ID_W-1:0]  old_q, cur_q, age;
  logic [CNT_W-1:0] cnt_q, drn_q, req, eff;
  logic [CNT_W:0]   sum;
  logic             hit, need;

  // position of the victim owner inside the list
  assign age      = conflict_id_i - old_q;
  assign hit      = conflict_i && ({1'b0, age} < (ID_W+1)'(cnt_q));
  assign req      = hit ? CNT_W'(age) + CNT_W'(1) : '0;
  assign on_run_o = hit && (req == cnt_q);
  assign eff      = (req > drn_q) ? req : drn_q;

  assign sum      = {1'b0, cnt_q} + (CNT_W+1)'(end_i);
  assign need     = sum > {1'b0, cap_i};
  // one commit serves both a pending drain and cap pressure
  assign commit_o    = (eff != '0) || need;
  assign commit_id_o = old_q;
  assign cur_o       = cur_q;
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q <= '0;
      cur_q <= '0;
      cnt_q <= CNT_W'(1);
      drn_q <= '0;
    end else begin
      old_q <= old_q + ID_W'(commit_o);
      cur_q <= cur_q + ID_W'(end_i);
      cnt_q <= CNT_W'(sum - (CNT_W+1)'(commit_o));
      drn_q <= (eff != '0) ? eff - CNT_W'(1) : '0;
    end
  end
endmodule

// File: rtl/epoch_ctrl.sv
`timescale 1ns/1ps
module epoch_ctrl
  import epoch_pkg::*;
#(
  parameter int unsigned SIZE_W   = 10,
  parameter int unsigned MAX_INST = 65536,
  parameter int unsigned ID_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] max_size_i,
  input  logic [1:0]        cap_sel_i,
  input  logic              line_new_i,
  input  logic              inst_ret_i,
  input  logic              sync_i,
  input  logic              conflict_i,
  input  logic [ID_W-1:0]   conflict_id_i,
  output logic              end_epoch_o,
  output logic [ID_W-1:0]   cur_epoch_o,
  output logic              commit_o,
  output logic [ID_W-1:0]   commit_id_o,
  output logic [3:0]        live_cnt_o
);
  localparam int unsigned INST_W = $clog2(MAX_INST + 1);

  logic size_hit, inst_hit, on_run;
  logic [CNT_W-1:0] cap;

  assign cap         = cap_decode(cap_sel_i);
  assign end_epoch_o = sync_i || size_hit || inst_hit || on_run;

  epoch_thr_cnt #(.W(SIZE_W)) u_size (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (end_epoch_o),
    .inc_i   (line_new_i),
    .limit_i (max_size_i),
    .hit_o   (size_hit)
  );

  epoch_thr_cnt #(.W(INST_W)) u_inst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (end_epoch_o),
    .inc_i   (inst_ret_i),
    .limit_i (INST_W'(MAX_INST)),
    .hit_o   (inst_hit)
  );

  epoch_list #(.ID_W(ID_W)) u_list (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .end_i         (end_epoch_o),
    .conflict_i    (conflict_i),
    .conflict_id_i (conflict_id_i),
    .cap_i         (cap),
    .on_run_o      (on_run),
    .commit_o      (commit_o),
    .commit_id_o   (commit_id_o),
    .cur_o         (cur_epoch_o),
    .cnt_o         (live_cnt_o)
  );
endmodule

// File: rtl/epoch_ctrl_chk.sv
`timescale 1ns/1ps
module epoch_ctrl_chk
  import epoch_pkg::*;
#(
  parameter int unsigned ID_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      cap_sel_i,
  input logic            sync_i,
  input logic            end_epoch_o,
  input logic [ID_W-1:0] cur_epoch_o,
  input logic            commit_o,
  input logic [ID_W-1:0] commit_id_o,
  input logic [3:0]      live_cnt_o
);
  logic [ID_W-1:0] last_q;
  logic            seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (commit_o) begin
      last_q <= commit_id_o;
      seen_q <= 1'b1;
    end
  end

  p_sync_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |-> end_epoch_o);

  p_end_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_epoch_o |=> (cur_epoch_o - $past(cur_epoch_o)) == ID_W'(1));

  p_id_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_epoch_o |=> $stable(cur_epoch_o));

  p_cap_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_epoch_o && live_cnt_o >= cap_decode(cap_sel_i)) |-> commit_o);

  p_live_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_cnt_o != 4'd0 && live_cnt_o <= 4'd8);

  p_live_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> live_cnt_o == 4'($past(live_cnt_o) + 4'($past(end_epoch_o)) - 4'($past(commit_o))));

  p_commit_seq_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && seen_q) |-> commit_id_o == last_q + ID_W'(1));

  p_commit_head_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> commit_id_o == cur_epoch_o - ID_W'(live_cnt_o - 4'd1));
endmodule

bind epoch_ctrl epoch_ctrl_chk #(.ID_W(ID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cap_sel_i   (cap_sel_i),
  .sync_i      (sync_i),
  .end_epoch_o (end_epoch_o),
  .cur_epoch_o (cur_epoch_o),
  .commit_o    (commit_o),
  .commit_id_o (commit_id_o),
  .live_cnt_o  (live_cnt_o)
);

// File: tb/sim_epoch_ctrl.sv
`timescale 1ns/1ps
module sim_epoch_ctrl;
  localparam int SW = 8;
  localparam int MI = 40;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [SW-1:0] max_size = 8'd5;
  logic [1:0]    cap_sel = 2'd2;
  logic          line_new = 0, inst_ret = 0, sync = 0, conflict = 0;
  logic [3:0]    conflict_id = '0;
  logic          end_epoch, commit;
  logic [3:0]    cur_epoch, commit_id, live_cnt;

  int cmp = 0, bad = 0;
  bit done = 0;

  // reference model state
  int q[$];
  int drain = 0, sz = 0, ic = 0;

  always #10 clk = ~clk;

  epoch_ctrl #(.SIZE_W(SW), .MAX_INST(MI), .ID_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .max_size_i(max_size), .cap_sel_i(cap_sel),
    .line_new_i(line_new), .inst_ret_i(inst_ret), .sync_i(sync),
    .conflict_i(conflict), .conflict_id_i(conflict_id),
    .end_epoch_o(end_epoch), .cur_epoch_o(cur_epoch), .commit_o(commit),
    .commit_id_o(commit_id), .live_cnt_o(live_cnt));

  task automatic check(input string req, input int act, input int exp);
    cmp++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      int cap, idx, eff;
      bit on_run, sh, ih, e_end, need, e_com;
      string te, tc;
      cap = (cap_sel == 2'd0) ? 2 : (cap_sel == 2'd1) ? 4 : 8;
      idx = -1;
      if (conflict) foreach (q[i]) if (q[i] == int'(conflict_id)) idx = i;
      on_run = (idx >= 0) && (idx == q.size() - 1);
      sh = line_new && (sz + 1 >= int'(max_size));
      ih = inst_ret && (ic + 1 >= MI);
      e_end = sync || sh || ih || on_run;
      eff = (drain > idx + 1) ? drain : idx + 1;
      need = (q.size() + int'(e_end)) > cap;
      e_com = (eff > 0) || need;
      te = sync ? "R4" : on_run ? "R10" : sh ? "R2" : ih ? "R3" : "R5";
      tc = (idx >= 0) ? "R8" : need ? "R7" : "R9";
      check(te, int'(end_epoch), int'(e_end));
      check(tc, int'(commit), int'(e_com));
      if (e_com) check("R12", int'(commit_id), q[0]);
      check("R6", int'(cur_epoch), q[q.size()-1]);
      check("R11", int'(live_cnt), q.size());
      if (e_end) q.push_back((q[q.size()-1] + 1) % 16);
      if (e_com) void'(q.pop_front());
      drain = (eff > 0) ? eff - 1 : 0;
      sz = e_end ? 0 : sz + int'(line_new);
      ic = e_end ? 0 : ic + int'(inst_ret);
    end
  end

  task automatic step(input bit ln, input bit in, input bit sy, input bit cf, input logic [3:0] cid);
    line_new = ln; inst_ret = in; sync = sy; conflict = cf; conflict_id = cid;
    @(posedge clk); #2;
    line_new = 0; inst_ret = 0; sync = 0; conflict = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
    $finish;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      cmp++; bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    q.push_back(0);
    #45 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(cur_epoch), 0);
    check("R1", int'(live_cnt), 1);
    check("R1", int'(end_epoch), 0);
    check("R1", int'(commit), 0);
    @(posedge clk); #2;
    // R2 footprint
    repeat (5) step(1, 0, 0, 0, 0);
    // R5 counters cleared by sync, R4
    repeat (3) step(1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    repeat (5) step(1, 0, 0, 0, 0);
    // R3 instruction limit
    repeat (MI) step(0, 1, 0, 0, 0);
    // R6 coincident causes
    repeat (4) step(1, 1, 0, 0, 0);
    step(1, 1, 1, 0, 0);
    // R7 cap reached
    repeat (10) step(0, 0, 1, 0, 0);
    // R11 lowered cap drains
    cap_sel = 2'd0;
    repeat (8) step(0, 0, 0, 0, 0);
    cap_sel = 2'd2;
    repeat (5) step(0, 0, 1, 0, 0);
    // R8 drain with ends during it
    step(0, 0, 0, 1, cur_epoch - 4'd3);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    repeat (6) step(0, 0, 0, 0, 0);
    // R9 stale id
    repeat (3) step(0, 0, 1, 0, 0);
    step(0, 0, 0, 1, cur_epoch + 4'd5);
    step(0, 0, 0, 0, 0);
    // R10 conflict on the running epoch
    step(0, 0, 0, 1, cur_epoch);
    repeat (10) step(0, 0, 0, 0, 0);
    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) == 0) cap_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 149) == 0) max_size = 8'($urandom_range(0, 8));
      step($urandom_range(0, 9) < 3, $urandom_range(0, 9) < 6,
           $urandom_range(0, 99) < 3, $urandom_range(0, 99) < 4,
           4'($urandom_range(0, 15)));
    end
    repeat (4) step(0, 0, 0, 0, 0);
    done = 1;
    finish_run();
  end
endmodule